// File: doc/BRIEF.md
# Circular Trace Buffer Memory Writer

This block sits between a source of compressed trace bytes and on-chip memory. Software sets a memory window with a base address and an exclusive limit address. It loads the write pointer from the base, picks loop or one-shot mode, and then starts a capture session. Each session writes a run of zero bytes first, which acts as a synchronization marker. Every incoming byte then goes through a small queue and is written to the next address in the window, one byte per cycle.

In loop mode the pointer returns to the base after the last address of the window, so the window always holds the newest data. Software finds where the valid data begins by scanning past the zero run. In one-shot mode writing stops at the limit. After that the queue fills, and any later bytes are dropped and counted as an overflow.

Two interrupt sources exist: memory-full and queue overflow. Each raw bit latches only while its enable is set, and software clears it by writing a one.

Top module: `trace_ring_writer`

## Requirements
- R1: Writing any value to offset 2 loads the write pointer from the base register (offset 0). Offset 3 reads the pointer at any time, and the value is the base plus the number of bytes written modulo the window size (limit at offset 1 minus base).
- R2: Accepting a start writes exactly 14 zero bytes at consecutive pointer addresses before any packet byte.
- R3: While a session runs, each byte presented with `pkt_valid` is written once to memory. Bytes keep their arrival order and go to consecutive addresses.
- R4: With loop mode set (offset 4 bit 0), a write to address limit-1 is followed by the pointer returning to the base, and writing continues from there.
- R5: A write to address limit-1 sets memory-full raw (offset 7 bit 0) only if memory-full enable (offset 8 bit 0) is set. Output `irq` is the OR of the raw bits.
- R6: With loop mode clear, writing stops after address limit-1 and the pointer reads the limit value. A later pointer load resumes draining the queue.
- R7: The queue holds 16 bytes. A byte that arrives while the queue is full is dropped and sets overflow raw (offset 7 bit 1) if overflow enable (offset 8 bit 1) is set. Status at offset 6 shows empty in bit 0 and full in bit 1.
- R8: Writing a one to a bit of offset 9 clears the matching raw bit, unless the same cycle sets it again.
- R9: Writing offset 5 bit 1 (stop) ends acceptance of new bytes, and bytes already queued are still written.
- R10: Offset 5 bit 0 (start) opens a session from the idle state. From the stopped state it does so only when restart enable (offset 4 bit 1) is set; otherwise it is ignored.
- R11: After reset the pointer is 0, the queue is empty, the raw bits are 0, `irq` is low and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Trace byte present this cycle |
| pkt_data | input | 8 | Trace byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer appears on `mem_addr` at the very next write and in the offset 3 readback in the same cycle. A wrong wrap therefore shows within one write of the limit. A bad preamble count moves every later packet byte by a fixed offset. A queue that drops, duplicates or reorders bytes shows up as a mismatch in the write stream as soon as the affected byte drains. Wrong interrupt gating shows on `irq` one cycle after the write to limit-1.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam logic [3:0] OFS_BASE   = 4'd0;
    localparam logic [3:0] OFS_LIMIT  = 4'd1;
    localparam logic [3:0] OFS_RELOAD = 4'd2;
    localparam logic [3:0] OFS_PTR    = 4'd3;
    localparam logic [3:0] OFS_MODE   = 4'd4;
    localparam logic [3:0] OFS_CMD    = 4'd5;
    localparam logic [3:0] OFS_FSTAT  = 4'd6;
    localparam logic [3:0] OFS_IRAW   = 4'd7;
    localparam logic [3:0] OFS_IEN    = 4'd8;
    localparam logic [3:0] OFS_ICLR   = 4'd9;

    typedef enum logic [1:0] {
        SES_IDLE = 2'd0,
        SES_RUN  = 2'd1,
        SES_HALT = 2'd2
    } ses_e;

    typedef struct packed {
        logic restart_en;
        logic wrap_en;
    } mode_t;

    typedef struct packed {
        logic ovf;
        logic full;
    } irq_t;

    function automatic irq_t irq_next(irq_t cur, irq_t clr, irq_t set_ev, irq_t en);
        return irq_t'((cur & ~clr) | (set_ev & en));
    endfunction

    function automatic logic start_ok(ses_e st, mode_t md);
        return (st == SES_IDLE) || (st == SES_HALT && md.restart_en);
    endfunction

endpackage

// File: rtl/trc_fifo.sv
module trc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign drop    = push && full;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_idx];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_idx <= (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + AW'(1);
            if (do_pop)  rd_idx <= (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == $past(count)));

    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/trc_writer.sv
module trc_writer #(
    parameter int AW  = 16,
    parameter int PRE = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          reload,
    input  logic          wrap_en,
    input  logic          sess_start,
    input  logic          q_empty,
    input  logic [7:0]    q_data,
    output logic          q_pop,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] ptr,
    output logic          hit_end
);
    localparam int PW = $clog2(PRE + 1);

    logic [PW-1:0] pre_cnt;
    logic          parked;
    logic          in_pre, busy;
    logic [AW-1:0] nxt;

    assign in_pre    = (pre_cnt != '0);
    assign busy      = !parked && (in_pre || !q_empty);
    assign q_pop     = busy && !in_pre;
    assign nxt       = ptr + AW'(1);
    assign hit_end   = busy && (nxt == limit);
    assign mem_we    = busy;
    assign mem_addr  = ptr;
    assign mem_wdata = in_pre ? 8'h00 : q_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (sess_start) begin
            pre_cnt <= PW'(PRE);
        end else if (busy && in_pre) begin
            pre_cnt <= pre_cnt - PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            parked <= 1'b0;
        end else if (reload) begin
            ptr    <= base;
            parked <= 1'b0;
        end else if (hit_end) begin
            ptr    <= wrap_en ? base : limit;
            parked <= !wrap_en;
        end else if (busy) begin
            ptr    <= nxt;
        end
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (hit_end && wrap_en) |=> (ptr == $past(base)));

    p_park_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_end && !wrap_en && !reload) |=> (ptr == $past(limit) && !mem_we));

    p_preamble_r2: assert property (@(posedge clk) disable iff (rst)
        (sess_start && (reload || !parked) && !hit_end) |=> (mem_we && mem_wdata == 8'h00));

endmodule

// File: rtl/trace_ring_writer.sv
module trace_ring_writer
    import trc_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int FIFO_DEPTH   = 16,
    parameter int PREAMBLE_LEN = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_data,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              irq
);
    logic [ADDR_W-1:0] base_q, limit_q, ptr;
    mode_t             mode_q;
    ses_e              ses_q;
    irq_t              raw_q, en_q, clr_ev, set_ev;

    logic wr_cmd, start_req, stop_req, sess_start, reload;
    logic q_push, q_pop, q_empty, q_full, q_drop, hit_end;
    logic [7:0] q_data;

    assign wr_cmd     = reg_we && (reg_addr == OFS_CMD);
    assign stop_req   = wr_cmd && reg_wdata[1];
    assign start_req  = wr_cmd && reg_wdata[0] && !reg_wdata[1];
    assign sess_start = start_req && start_ok(ses_q, mode_q);
    assign reload     = reg_we && (reg_addr == OFS_RELOAD);
    assign q_push     = pkt_valid && (ses_q == SES_RUN);

    trc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (pkt_data),
        .pop   (q_pop),
        .dout  (q_data),
        .empty (q_empty),
        .full  (q_full),
        .drop  (q_drop)
    );

    trc_writer #(.AW(ADDR_W), .PRE(PREAMBLE_LEN)) u_writer (
        .clk        (clk),
        .rst        (rst),
        .base       (base_q),
        .limit      (limit_q),
        .reload     (reload),
        .wrap_en    (mode_q.wrap_en),
        .sess_start (sess_start),
        .q_empty    (q_empty),
        .q_data     (q_data),
        .q_pop      (q_pop),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .ptr        (ptr),
        .hit_end    (hit_end)
    );

    assign set_ev = '{ovf: q_drop, full: hit_end};
    assign clr_ev = (reg_we && reg_addr == OFS_ICLR) ? irq_t'(reg_wdata[1:0]) : irq_t'(2'b00);
    assign irq    = |raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '0;
            mode_q  <= '0;
            en_q    <= '0;
            raw_q   <= '0;
            ses_q   <= SES_IDLE;
        end else begin
            if (reg_we && reg_addr == OFS_BASE)  base_q  <= reg_wdata;
            if (reg_we && reg_addr == OFS_LIMIT) limit_q <= reg_wdata;
            if (reg_we && reg_addr == OFS_MODE)  mode_q  <= mode_t'(reg_wdata[1:0]);
            if (reg_we && reg_addr == OFS_IEN)   en_q    <= irq_t'(reg_wdata[1:0]);
            raw_q <= irq_next(raw_q, clr_ev, set_ev, en_q);
            if (stop_req && ses_q == SES_RUN) ses_q <= SES_HALT;
            else if (sess_start)              ses_q <= SES_RUN;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE:  reg_rdata = base_q;
            OFS_LIMIT: reg_rdata = limit_q;
            OFS_PTR:   reg_rdata = ptr;
            OFS_MODE:  reg_rdata = ADDR_W'(mode_q);
            OFS_FSTAT: reg_rdata = ADDR_W'({q_full, q_empty});
            OFS_IRAW:  reg_rdata = ADDR_W'(raw_q);
            OFS_IEN:   reg_rdata = ADDR_W'(en_q);
            default:   reg_rdata = '0;
        endcase
    end

    p_full_gate_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q.full) |-> $past(en_q.full));

    p_ovf_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q.ovf) |-> $past(en_q.ovf));

    p_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (ses_q != SES_RUN) |-> !q_drop);

    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (ses_q == SES_HALT && !mode_q.restart_en) |=> (ses_q == SES_HALT));

endmodule

// File: tb/trace_ring_writer_test.sv
module trace_ring_writer_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [7:0]  pkt_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    int wr_cnt = 0;
    logic [15:0] log_a [0:1023];
    logic [7:0]  log_d [0:1023];

    trace_ring_writer uut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            log_a[wr_cnt % 1024] = mem_addr;
            log_d[wr_cnt % 1024] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic feed(input int n, input logic [7:0] first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pkt_valid = 1'b1; pkt_data = first + 8'(i);
        end
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int mark;
        do_reset();

        // R11 reset state
        reg_read(4'd3, rd); check("R11 ptr", rd, 0);
        reg_read(4'd6, rd); check("R11 fifo status", rd, 1);
        reg_read(4'd7, rd); check("R11 raw", rd, 0);
        check("R11 irq", irq, 0);
        check("R11 mem_we", mem_we, 0);

        // loop window 0x100..0x128 (40 bytes)
        reg_write(4'd0, 16'h0100);
        reg_write(4'd1, 16'h0128);
        reg_write(4'd4, 16'h0003);
        reg_write(4'd8, 16'h0003);
        reg_write(4'd2, 16'h0001);
        reg_read(4'd3, rd); check("R1 reload", rd, 16'h0100);

        mark = wr_cnt;
        reg_write(4'd5, 16'h0001);
        feed(20, 8'd1);
        repeat (40) @(negedge clk);
        reg_write(4'd5, 16'h0002);
        repeat (5) @(negedge clk);
        check("R3 write count", wr_cnt - mark, 34);
        for (int i = 0; i < 14; i++) begin
            check("R2 preamble addr", log_a[mark + i], 16'h0100 + i);
            check("R2 preamble data", log_d[mark + i], 0);
        end
        for (int j = 0; j < 20; j++) begin
            check("R3 packet addr", log_a[mark + 14 + j], 16'h0100 + 14 + j);
            check("R3 packet data", log_d[mark + 14 + j], 1 + j);
        end
        reg_read(4'd3, rd); check("R1 ptr after session", rd, 16'h0100 + 34);
        reg_read(4'd7, rd); check("R5 raw clear before end", rd, 0);

        // R9 bytes after stop are ignored
        mark = wr_cnt;
        feed(5, 8'hA0);
        repeat (20) @(negedge clk);
        check("R9 no writes after stop", wr_cnt - mark, 0);
        reg_read(4'd6, rd); check("R9 fifo empty", rd, 1);
        reg_read(4'd3, rd); check("R9 ptr unchanged", rd, 16'h0100 + 34);

        // R10 restart with restart enable, R4 wrap
        mark = wr_cnt;
        reg_write(4'd5, 16'h0001);
        feed(10, 8'h30);
        repeat (40) @(negedge clk);
        check("R4 write count", wr_cnt - mark, 24);
        for (int k = 0; k < 24; k++) begin
            check("R4 wrap addr", log_a[mark + k], 16'h0100 + ((34 + k) % 40));
            check("R4 wrap data", log_d[mark + k], (k < 14) ? 0 : 8'h30 + k - 14);
        end
        reg_read(4'd3, rd); check("R1 ptr modulo", rd, 16'h0100 + 18);
        reg_read(4'd7, rd); check("R5 memfull raw", rd, 1);
        check("R5 irq", irq, 1);
        reg_write(4'd9, 16'h0001);
        reg_read(4'd7, rd); check("R8 w1c memfull", rd, 0);
        check("R8 irq low", irq, 0);

        // R10 restart disabled
        reg_write(4'd4, 16'h0001);
        reg_write(4'd5, 16'h0002);
        mark = wr_cnt;
        reg_write(4'd5, 16'h0001);
        feed(5, 8'h50);
        repeat (20) @(negedge clk);
        check("R10 start ignored", wr_cnt - mark, 0);
        reg_read(4'd3, rd); check("R10 ptr unchanged", rd, 16'h0100 + 18);

        // one-shot window 0x200..0x214 (20 bytes)
        do_reset();
        reg_write(4'd0, 16'h0200);
        reg_write(4'd1, 16'h0214);
        reg_write(4'd4, 16'h0000);
        reg_write(4'd8, 16'h0002);
        reg_write(4'd2, 16'h0001);
        mark = wr_cnt;
        reg_write(4'd5, 16'h0001);
        feed(40, 8'd1);
        repeat (10) @(negedge clk);
        check("R6 write count", wr_cnt - mark, 20);
        reg_read(4'd3, rd); check("R6 ptr at limit", rd, 16'h0214);
        reg_read(4'd7, rd);
        check("R5 memfull gated", rd[0], 0);
        check("R7 overflow raw", rd[1], 1);
        reg_read(4'd6, rd); check("R7 fifo full", rd, 2);
        for (int j = 0; j < 6; j++) begin
            check("R3 one-shot addr", log_a[mark + 14 + j], 16'h020E + j);
            check("R3 one-shot data", log_d[mark + 14 + j], 1 + j);
        end
        reg_write(4'd2, 16'h0001);
        repeat (30) @(negedge clk);
        check("R6 resumed count", wr_cnt - mark, 36);
        for (int m = 0; m < 16; m++) begin
            check("R7 kept addr", log_a[mark + 20 + m], 16'h0200 + m);
            check("R7 kept data", log_d[mark + 20 + m], 7 + m);
        end
        reg_read(4'd3, rd); check("R6 ptr after drain", rd, 16'h0210);
        reg_read(4'd6, rd); check("R7 fifo empty after drain", rd, 1);
        reg_write(4'd9, 16'h0002);
        reg_read(4'd7, rd); check("R8 w1c overflow", rd, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule